// File: doc/BRIEF.md
# Page Write Buffer with Write Protection

This unit sits between the serial protocol engine of a small byte-wide nonvolatile memory and its storage array. The engine gives it a starting word address and then a stream of data bytes, each already received and acknowledged. The unit holds them in a one-page staging buffer. The low address bits count around inside an 8-byte page, and the upper bits stay fixed. If more than a page of bytes arrives, later bytes overwrite earlier ones. A per-slot valid mask records which page slots hold a byte.

When the engine reports a bus STOP and at least one byte is staged, the unit starts a commit. It samples the protection pin once at that moment and raises `busy` for a fixed, parameterised number of cycles. During that interval it writes the loaded slots to the array through a simple write port, unless the page is protected. While `busy` is high the unit accepts no new instruction. A START before the STOP throws the staged bytes away. The word-address counter reached by the last byte is reported on `cnt_out` from the start of the commit.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` is 0, `cnt_out` is 0 and `mem_we` is 0.
- R2: Each accepted byte goes to slot `addr[2:0]` of the page `addr[AW-1:3]`. The counter then advances only its low 3 bits, going from 7 back to 0, and the upper bits never change.
- R3: When more than 8 bytes arrive before STOP, the array receives the last 8 bytes sent.
- R4: A commit starts only on a `stop_seen` pulse while at least one byte is staged. A STOP with no staged byte leaves `busy` low and writes nothing.
- R5: A `start_seen` pulse discards every staged byte. A following STOP then causes no busy interval and no array write, and leaves `cnt_out` unchanged.
- R6: `busy` rises in the cycle after the STOP pulse and stays high for exactly WRITE_CYCLES cycles (at least PAGE_BYTES+2). While it is high, `addr_load`, `byte_valid`, `start_seen` and `stop_seen` have no effect, and `mem_we` is only ever asserted while it is high.
- R7: With the protection pin high at commit start, a memory of 128 bytes or fewer blocks every address. A larger memory blocks only the upper half: addresses whose top bit is 1, which is 80h to FFh for 256 bytes.
- R8: The protection pin is sampled once, in the cycle the commit starts. Changing it during `busy` neither aborts an allowed commit nor enables a blocked one.
- R9: Only slots that received a byte in the current instruction are written: one `mem_we` pulse per loaded slot, at most 8.
- R10: A protected commit still holds `busy` for the full interval and writes nothing.
- R11: From commit start, `cnt_out` equals the address following the last staged byte, counted inside the page. A write that ends at the last address of a page therefore reports the first address of that page. Protected commits update `cnt_out` as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin | input | 1 | Write-protect level, sampled at commit start |
| addr_load | input | 1 | Pulse: load the starting word address and clear the staged bytes |
| addr_in | input | $clog2(MEM_BYTES) | Starting word address |
| byte_valid | input | 1 | Pulse: one acknowledged data byte |
| byte_in | input | 8 | Data byte |
| start_seen | input | 1 | Pulse: bus START, discards staged data |
| stop_seen | input | 1 | Pulse: bus STOP, starts a commit when data is staged |
| busy | output | 1 | Commit interval in progress |
| cnt_out | output | $clog2(MEM_BYTES) | Word-address counter after the last commit |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | $clog2(MEM_BYTES) | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume that the engine raises at most one of `start_seen`, `addr_load`, `byte_valid` and `stop_seen` in a given cycle, and that each pulse lasts one cycle. They also assume `wp_pin` is a clean synchronous level. The bench drives each pulse alone for a single cycle on the falling clock edge and changes `wp_pin` only on falling edges. Pulses that arrive during `busy` are deliberately sent one at a time, so that the ignore rule is tested without breaking the one-pulse-per-cycle rule.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_BUSY = 1'b1
  } commit_state_e;

  // Busy interval must cover the slot scan plus the registered write strobe.
  function automatic int unsigned busy_len(int unsigned req, int unsigned page);
    return (req < page + 2) ? page + 2 : req;
  endfunction

endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
  parameter int AW         = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept_en,
  input  logic                          addr_load,
  input  logic [AW-1:0]                 addr_in,
  input  logic                          byte_valid,
  input  logic [7:0]                    byte_in,
  input  logic                          discard,
  input  logic                          clear,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_slot,
  output logic [7:0]                    rd_data,
  output logic [PAGE_BYTES-1:0]         slot_mask,
  output logic [AW-1:0]                 wptr
);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [AW-1:0]         ptr_q, ptr_d;
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PW-1:0]         low;
  logic                  take_byte;

  assign low       = ptr_q[PW-1:0];
  assign take_byte = accept_en && byte_valid && !discard && !addr_load;

  always_comb begin
    mask_d = mask_q;
    ptr_d  = ptr_q;
    if (clear) begin
      mask_d = '0;
    end else if (accept_en) begin
      if (discard) begin
        mask_d = '0;
      end else if (addr_load) begin
        mask_d = '0;
        ptr_d  = addr_in;
      end else if (byte_valid) begin
        mask_d[low]     = 1'b1;
        ptr_d[PW-1:0]   = low + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
    end else begin
      mask_q <= mask_d;
      ptr_q  <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) data_q[i] <= '0;
    end else if (take_byte) begin
      data_q[low] <= byte_in;
    end
  end

  assign rd_data   = data_q[rd_slot];
  assign slot_mask = mask_q;
  assign wptr      = ptr_q;

  // R2: accepting a byte never moves the counter to another page
  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |=> wptr[AW-1:PW] == $past(wptr[AW-1:PW]));

  // R6: staged state is frozen while a commit runs
  assert_frozen_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_en && !clear) |=> ($stable(slot_mask) && $stable(wptr)));

  // R5: a discard leaves nothing staged
  assert_discard_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_en && discard) |=> slot_mask == '0);

endmodule

// File: rtl/pwb_protect.sv
module pwb_protect #(
  parameter int AW         = 8,
  parameter int PW         = 3,
  parameter int MEM_BYTES  = 256,
  parameter int FULL_LIMIT = 128
) (
  input  logic            wp_lat,
  input  logic [AW-PW-1:0] page_base,
  output logic            prot_hit
);
  generate
    if (MEM_BYTES <= FULL_LIMIT) begin : g_whole
      assign prot_hit = wp_lat;
    end else begin : g_upper_half
      assign prot_hit = wp_lat && page_base[AW-PW-1];
    end
  endgenerate
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
  parameter int          AW         = 8,
  parameter int          PAGE_BYTES = 8,
  parameter int unsigned BUSY_LEN   = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stop_seen,
  input  logic                          wp_pin,
  input  logic [PAGE_BYTES-1:0]         slot_mask,
  input  logic [AW-1:0]                 wptr,
  input  logic [7:0]                    rd_data,
  input  logic                          prot_hit,
  output logic [$clog2(PAGE_BYTES)-1:0] rd_slot,
  output logic                          busy,
  output logic                          done,
  output logic                          wp_lat,
  output logic [AW-$clog2(PAGE_BYTES)-1:0] page_base,
  output logic [AW-1:0]                 cnt_out,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [7:0]                    mem_wdata
);
  import pwb_pkg::*;
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = AW - PW;
  localparam int TW = $clog2(BUSY_LEN + 1);

  commit_state_e state_q, state_d;
  logic [TW-1:0] timer_q, timer_d;
  logic [PW:0]   slot_q, slot_d;
  logic          wp_q, wp_d;
  logic [BW-1:0] base_q, base_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    wdata_q, wdata_d;
  logic          go;

  assign go   = (state_q == CS_IDLE) && stop_seen && (|slot_mask);
  assign done = (state_q == CS_BUSY) && (timer_q == '0);

  always_comb begin
    state_d = state_q;
    timer_d = timer_q;
    slot_d  = slot_q;
    wp_d    = wp_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    if (go) begin
      state_d = CS_BUSY;
      timer_d = TW'(BUSY_LEN - 1);
      slot_d  = '0;
      wp_d    = wp_pin;
      base_d  = wptr[AW-1:PW];
      cnt_d   = wptr;
    end else if (state_q == CS_BUSY) begin
      if (done) state_d = CS_IDLE;
      else      timer_d = timer_q - 1'b1;
      if (!slot_q[PW]) slot_d = slot_q + 1'b1;
    end
  end

  always_comb begin
    we_d    = (state_q == CS_BUSY) && !slot_q[PW] &&
              slot_mask[slot_q[PW-1:0]] && !prot_hit;
    addr_d  = {base_q, slot_q[PW-1:0]};
    wdata_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      timer_q <= '0;
      slot_q  <= '0;
      wp_q    <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      timer_q <= timer_d;
      slot_q  <= slot_d;
      wp_q    <= wp_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      we_q    <= we_d;
      if (we_d) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign rd_slot   = slot_q[PW-1:0];
  assign busy      = (state_q == CS_BUSY);
  assign wp_lat    = wp_q;
  assign page_base = base_q;
  assign cnt_out   = cnt_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R4: a busy interval is always caused by a STOP
  assert_busy_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_seen));

  // R6: array writes only inside the busy interval
  assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R8: latched protection level holds for the whole interval
  assert_wp_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wp_lat));

  // R2: every write stays inside the page captured at commit start
  assert_write_in_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[AW-1:PW] == page_base);

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int          MEM_BYTES    = 256,
  parameter int          PAGE_BYTES   = 8,
  parameter int unsigned WRITE_CYCLES = 1250000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wp_pin,
  input  logic                         addr_load,
  input  logic [$clog2(MEM_BYTES)-1:0] addr_in,
  input  logic                         byte_valid,
  input  logic [7:0]                   byte_in,
  input  logic                         start_seen,
  input  logic                         stop_seen,
  output logic                         busy,
  output logic [$clog2(MEM_BYTES)-1:0] cnt_out,
  output logic                         mem_we,
  output logic [$clog2(MEM_BYTES)-1:0] mem_addr,
  output logic [7:0]                   mem_wdata
);
  localparam int          AW       = $clog2(MEM_BYTES);
  localparam int          PW       = $clog2(PAGE_BYTES);
  localparam int          BW       = AW - PW;
  localparam int unsigned BUSY_LEN = pwb_pkg::busy_len(WRITE_CYCLES, PAGE_BYTES);

  logic [PAGE_BYTES-1:0] slot_mask;
  logic [AW-1:0]         wptr;
  logic [7:0]            rd_data;
  logic [PW-1:0]         rd_slot;
  logic                  done, wp_lat, prot_hit;
  logic [BW-1:0]         page_base;

  pwb_page_store #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_en (!busy),
    .addr_load (addr_load),
    .addr_in   (addr_in),
    .byte_valid(byte_valid),
    .byte_in   (byte_in),
    .discard   (start_seen),
    .clear     (done),
    .rd_slot   (rd_slot),
    .rd_data   (rd_data),
    .slot_mask (slot_mask),
    .wptr      (wptr)
  );

  pwb_protect #(.AW(AW), .PW(PW), .MEM_BYTES(MEM_BYTES), .FULL_LIMIT(128)) u_prot (
    .wp_lat   (wp_lat),
    .page_base(page_base),
    .prot_hit (prot_hit)
  );

  pwb_commit_seq #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .BUSY_LEN(BUSY_LEN)) u_commit (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_seen(stop_seen),
    .wp_pin   (wp_pin),
    .slot_mask(slot_mask),
    .wptr     (wptr),
    .rd_data  (rd_data),
    .prot_hit (prot_hit),
    .rd_slot  (rd_slot),
    .busy     (busy),
    .done     (done),
    .wp_lat   (wp_lat),
    .page_base(page_base),
    .cnt_out  (cnt_out),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  generate
    if (MEM_BYTES <= 128) begin : g_chk_whole
      // R7: small memory, protected commit writes nowhere
      assert_prot_whole_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wp_lat);
    end else begin : g_chk_half
      // R7: large memory, protected commit never touches the upper half
      assert_prot_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp_lat) |-> !mem_addr[AW-1]);
    end
  endgenerate

endmodule

// File: tb/tb_page_write_buffer.sv
module tb_page_write_buffer;
  localparam int WC = 16;

  logic clk, rst_n;
  logic wp, ld, bv, st, sp;
  logic [7:0] ldaddr, bdata;
  logic busy, mem_we, busy_s, mem_we_s;
  logic [7:0] cnt_out, mem_addr, mem_wdata, mem_wdata_s;
  logic [6:0] cnt_s, mem_addr_s;

  int checks = 0, failures = 0, cyc = 0;
  int wr_count = 0, wr_small = 0;
  logic [7:0] shadow [256];
  logic [7:0] expm   [256];

  page_write_buffer #(.MEM_BYTES(256), .PAGE_BYTES(8), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp), .addr_load(ld), .addr_in(ldaddr),
    .byte_valid(bv), .byte_in(bdata), .start_seen(st), .stop_seen(sp),
    .busy(busy), .cnt_out(cnt_out), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata));

  page_write_buffer #(.MEM_BYTES(128), .PAGE_BYTES(8), .WRITE_CYCLES(WC)) dut_small (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp), .addr_load(ld), .addr_in(ldaddr[6:0]),
    .byte_valid(bv), .byte_in(bdata), .start_seen(st), .stop_seen(sp),
    .busy(busy_s), .cnt_out(cnt_s), .mem_we(mem_we_s), .mem_addr(mem_addr_s),
    .mem_wdata(mem_wdata_s));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (mem_we) begin
      shadow[mem_addr] = mem_wdata;
      wr_count++;
    end
    if (mem_we_s) wr_small++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input int which, input logic [7:0] val);
    @(negedge clk);
    case (which)
      0: begin ld = 1'b1; ldaddr = val; end
      1: begin bv = 1'b1; bdata = val; end
      2: st = 1'b1;
      default: sp = 1'b1;
    endcase
    @(negedge clk);
    ld = 1'b0; bv = 1'b0; st = 1'b0; sp = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic mem_compare(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < 256; i++)
      if (bad < 0 && shadow[i] !== expm[i]) bad = i;
    if (bad < 0) chk(1'b1, req, "array contents", 0, 0);
    else chk(1'b0, req, $sformatf("array byte %0h", bad), shadow[bad], expm[bad]);
  endtask

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] n;
    logic [7:0] seed;
    logic       wp;
    logic [7:0] exp_cnt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{addr: 8'h10, n: 8'd1,  seed: 8'hA1, wp: 1'b0, exp_cnt: 8'h11},
    '{addr: 8'h23, n: 8'd8,  seed: 8'h30, wp: 1'b0, exp_cnt: 8'h23},
    '{addr: 8'h45, n: 8'd11, seed: 8'h50, wp: 1'b0, exp_cnt: 8'h40},
    '{addr: 8'h90, n: 8'd3,  seed: 8'h70, wp: 1'b1, exp_cnt: 8'h93},
    '{addr: 8'h30, n: 8'd2,  seed: 8'h80, wp: 1'b1, exp_cnt: 8'h32},
    '{addr: 8'hFE, n: 8'd4,  seed: 8'hC0, wp: 1'b0, exp_cnt: 8'hFA}
  };

  initial begin
    int n, w0, s0, c0;
    vec_t v;
    logic [7:0] a;
    for (int i = 0; i < 256; i++) begin shadow[i] = 8'h00; expm[i] = 8'h00; end
    wp = 1'b0; ld = 1'b0; bv = 1'b0; st = 1'b0; sp = 1'b0; ldaddr = '0; bdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(cnt_out == 8'h00, "R1", "cnt_out after reset", cnt_out, 0);
    chk(mem_we == 1'b0 && wr_count == 0, "R1", "no write after reset", wr_count, 0);

    // Table-driven commits: R2 R3 R7 R9 R10 R11
    for (int t = 0; t < 6; t++) begin
      v = VECS[t];
      w0 = wr_count; s0 = wr_small;
      wp = v.wp;
      pulse(0, v.addr);
      for (int k = 0; k < int'(v.n); k++) begin
        a = {v.addr[7:3], 3'(v.addr[2:0] + 3'(k))};
        if (!(v.wp && a[7])) expm[a] = 8'(v.seed + 8'(k));
        pulse(1, 8'(v.seed + 8'(k)));
      end
      pulse(3, 8'h00);
      wait_idle(n);
      mem_compare(v.n > 8 ? "R3" : "R2");
      chk(cnt_out == v.exp_cnt, "R11", $sformatf("cnt_out vec%0d", t), cnt_out, v.exp_cnt);
      chk(n == WC, v.wp ? "R10" : "R6", $sformatf("busy length vec%0d", t), n, WC);
      chk(wr_count - w0 == ((v.wp && v.addr[7]) ? 0 : (v.n > 8 ? 8 : int'(v.n))),
          "R9", $sformatf("write count vec%0d", t), wr_count - w0,
          (v.wp && v.addr[7]) ? 0 : (v.n > 8 ? 8 : int'(v.n)));
      chk(wr_small - s0 == (v.wp ? 0 : (v.n > 8 ? 8 : int'(v.n))),
          "R7", $sformatf("small-array writes vec%0d", t), wr_small - s0,
          v.wp ? 0 : (v.n > 8 ? 8 : int'(v.n)));
    end
    wp = 1'b0;

    // R5: START discards staged byte
    w0 = wr_count; c0 = cnt_out;
    pulse(0, 8'h50); pulse(1, 8'h77); pulse(2, 8'h00); pulse(3, 8'h00);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R5", "busy after discarded write", busy, 0);
    chk(wr_count == w0, "R5", "writes after discard", wr_count - w0, 0);
    chk(cnt_out == c0, "R5", "cnt_out after discard", cnt_out, c0);

    // R4: STOP with nothing staged
    pulse(0, 8'h60); pulse(3, 8'h00);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && wr_count == w0, "R4", "stop without data", wr_count - w0, 0);

    // R6: pulses during busy are ignored
    w0 = wr_count;
    pulse(0, 8'h08); pulse(1, 8'h5A); pulse(3, 8'h00);
    chk(busy == 1'b1, "R6", "busy after stop", busy, 1);
    pulse(0, 8'h70); pulse(1, 8'h99); pulse(2, 8'h00); pulse(3, 8'h00);
    wait_idle(n);
    expm[8'h08] = 8'h5A;
    mem_compare("R6");
    chk(wr_count - w0 == 1, "R6", "writes with busy-time pulses", wr_count - w0, 1);
    chk(cnt_out == 8'h09, "R6", "cnt_out with busy-time pulses", cnt_out, 8'h09);
    pulse(3, 8'h00);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R6", "stale data not recommitted", busy, 0);

    // R8: pin raised mid-commit does not abort
    wp = 1'b0;
    pulse(0, 8'hA0); pulse(1, 8'h11); pulse(3, 8'h00);
    wp = 1'b1;
    wait_idle(n);
    expm[8'hA0] = 8'h11;
    chk(shadow[8'hA0] == 8'h11, "R8", "write kept after pin rise", shadow[8'hA0], 8'h11);
    // R8: pin dropped mid-commit does not enable
    pulse(0, 8'hA8); pulse(1, 8'h22); pulse(3, 8'h00);
    wp = 1'b0;
    wait_idle(n);
    chk(shadow[8'hA8] == 8'h00, "R8", "blocked write stays blocked", shadow[8'hA8], 0);
    mem_compare("R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule